// File: doc/BRIEF.md
# Program Fetch Address Sequencer

This block holds the 16-bit program counter of a small 8-bit controller core and decides, for every instruction fetch, whether the address goes to on-chip or off-chip program memory. A strap input picks the mode. With the strap high, the lowest 4 KB of the address space is served on chip and everything above goes off chip. With the strap low, every fetch goes off chip.

The counter clears to zero on reset. It moves forward by one on each fetch-advance strobe, or takes a new target from a jump-load port. When an interrupt request is taken, it jumps to a fixed entry point. Five request lines map to entries spaced eight bytes apart, starting at 0003h. A request is taken only at an instruction boundary, which the fetch-advance strobe marks, and only while no other interrupt is in service. When a request is taken, the sequencer raises a one-cycle acknowledge, reports which source was taken and returns the counter value from before the jump, so the core can push it. A return pulse ends the service period.

Top module: `fetch_seq`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `fetchAddr` is 0000h and `irqAck` is 0.
- R2: With no jump load and no accepted interrupt, `fetchAddr` rises by one in the cycle after each cycle in which `fetchAdv` is high, wrapping from FFFFh to 0000h, and stays unchanged in cycles without `fetchAdv`.
- R3: When `jumpLoad` is high and no interrupt is accepted, the next `fetchAddr` is `jumpTarget`, even if `fetchAdv` is also high.
- R4: With `extStrap` high, `fetchExt` is 0 when `fetchAddr` is below 1000h and 1 when it is 1000h or above.
- R5: With `extStrap` low, `fetchExt` is 1 at every address, 0000h included.
- R6: Request bit k of `irqReq` (0: external 0, 1: timer 0, 2: external 1, 3: timer 1, 4: serial port), once accepted, sets `fetchAddr` to 0003h + 8*k in the next cycle, with `irqIdx` = k.
- R7: When several request bits are set in the accepting cycle, the lowest set bit index, which has the lowest entry address, is taken.
- R8: A request is accepted only in a cycle where `fetchAdv` is high. In other cycles it changes neither `fetchAddr` nor `irqAck`.
- R9: After an acceptance, no further request is accepted until a cycle with `retiPulse` high has been seen. From the cycle after that pulse, requests are accepted again.
- R10: An accepted request raises `irqAck` for exactly one cycle, the cycle right after acceptance. In that cycle `retAddr` holds the `fetchAddr` of the accepting cycle. Acceptance takes precedence over `jumpLoad` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extStrap | input | 1 | High: low 4 KB on chip; low: all fetches off chip |
| fetchAdv | input | 1 | Fetch strobe and instruction boundary marker |
| jumpLoad | input | 1 | Load `jumpTarget` into the counter |
| jumpTarget | input | 16 | Jump target address |
| irqReq | input | 5 | Interrupt request lines, bit 0 has the lowest entry address |
| retiPulse | input | 1 | Return from interrupt, ends the service period |
| fetchAddr | output | 16 | Current program fetch address |
| fetchExt | output | 1 | 1 selects off-chip program memory for this fetch |
| irqAck | output | 1 | One-cycle acknowledge of an accepted request |
| irqIdx | output | 3 | Index of the last accepted source |
| retAddr | output | 16 | Counter value at the last acceptance |

## Verification
The bench steps the counter across the 0FFFh/1000h boundary under both strap settings. An off-by-one limit compare, or a select that ignores the strap, would show up as a wrong `fetchExt` at that edge or at 0000h. It applies all 31 non-empty request masks and expects the lowest set bit at entry 0003h + 8k, which catches a reversed priority or a wrong stride. It raises requests without a fetch strobe, during service and together with a jump. A design that accepted requests off the boundary, nested them before the return pulse or let the jump win would move the counter to the wrong place. It also loads FFFFh and advances to catch a counter that saturates instead of wrapping.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;
  parameter int ADDR_W        = 16;
  parameter int NUM_IRQ       = 5;
  parameter int IDX_W         = $clog2(NUM_IRQ);
  parameter int ON_CHIP_BYTES = 4096;
  parameter int VEC_BASE      = 3;
  parameter int VEC_STRIDE    = 8;

  typedef struct packed {
    logic             loadVec;
    logic             loadJump;
    logic             incr;
    logic [IDX_W-1:0] vecIdx;
  } seqStrobes_t;
endpackage

// File: rtl/fetch_seq_ctl.sv
module fetch_seq_ctl
  import fetch_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchAdv,
  input  logic               jumpLoad,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               retiPulse,
  output seqStrobes_t        strb,
  output logic               irqAck,
  output logic [IDX_W-1:0]   irqIdx
);
  logic             inService;
  logic             accept;
  logic [IDX_W-1:0] winIdx;

  // scan from the top so the lowest set bit is the last one written
  always_comb begin
    winIdx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (irqReq[i]) winIdx = IDX_W'(i);
    end
  end

  assign accept = fetchAdv && !inService && (|irqReq);

  always_comb begin
    strb.loadVec  = accept;
    strb.loadJump = !accept && jumpLoad;
    strb.incr     = !accept && !jumpLoad && fetchAdv;
    strb.vecIdx   = winIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inService <= 1'b0;
      irqAck    <= 1'b0;
      irqIdx    <= '0;
    end else begin
      irqAck <= accept;
      if (accept) begin
        inService <= 1'b1;
        irqIdx    <= winIdx;
      end else if (retiPulse) begin
        inService <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fetch_seq_dp.sv
module fetch_seq_dp
  import fetch_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              extStrap,
  input  seqStrobes_t       strb,
  input  logic [ADDR_W-1:0] jumpTarget,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] retAddr,
  output logic              fetchExt
);
  localparam logic [ADDR_W-1:0] ON_CHIP_LIMIT = ADDR_W'(ON_CHIP_BYTES);

  logic [ADDR_W-1:0] vecAddr;

  assign vecAddr  = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STRIDE) * ADDR_W'(strb.vecIdx);
  assign fetchExt = !extStrap || (pc >= ON_CHIP_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc      <= '0;
      retAddr <= '0;
    end else begin
      if (strb.loadVec) begin
        pc      <= vecAddr;
        retAddr <= pc;
      end else if (strb.loadJump) begin
        pc <= jumpTarget;
      end else if (strb.incr) begin
        pc <= pc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               extStrap,
  input  logic               fetchAdv,
  input  logic               jumpLoad,
  input  logic [ADDR_W-1:0]  jumpTarget,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               retiPulse,
  output logic [ADDR_W-1:0]  fetchAddr,
  output logic               fetchExt,
  output logic               irqAck,
  output logic [IDX_W-1:0]   irqIdx,
  output logic [ADDR_W-1:0]  retAddr
);
  seqStrobes_t strb;

  fetch_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .fetchAdv(fetchAdv), .jumpLoad(jumpLoad),
    .irqReq(irqReq), .retiPulse(retiPulse), .strb(strb),
    .irqAck(irqAck), .irqIdx(irqIdx)
  );

  fetch_seq_dp u_dp (
    .clk(clk), .rstN(rstN), .extStrap(extStrap), .strb(strb),
    .jumpTarget(jumpTarget), .pc(fetchAddr), .retAddr(retAddr),
    .fetchExt(fetchExt)
  );
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk
  import fetch_seq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               extStrap,
  input logic               fetchAdv,
  input logic               jumpLoad,
  input logic [ADDR_W-1:0]  jumpTarget,
  input logic [NUM_IRQ-1:0] irqReq,
  input logic               retiPulse,
  input logic [ADDR_W-1:0]  fetchAddr,
  input logic               fetchExt,
  input logic               irqAck,
  input logic [IDX_W-1:0]   irqIdx,
  input logic [ADDR_W-1:0]  retAddr
);
  p_adv_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fetchAdv && !jumpLoad && irqReq == '0) |=> fetchAddr == $past(fetchAddr) + 1'b1);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchAdv && !jumpLoad) |=> $stable(fetchAddr));

  p_jump_r3: assert property (@(posedge clk) disable iff (!rstN)
    (jumpLoad && irqReq == '0) |=> fetchAddr == $past(jumpTarget));

  p_strap_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    !extStrap |-> fetchExt);

  p_vector_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |-> fetchAddr == ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STRIDE) * ADDR_W'(irqIdx));

  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> !irqAck);

  p_ret_addr_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |-> retAddr == $past(fetchAddr));
endmodule

bind fetch_seq fetch_seq_chk u_chk (.*);

// File: tb/sim_fetch_seq.sv
`timescale 1ns/1ps
module sim_fetch_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extStrap = 1'b1;
  logic        fetchAdv = 1'b0;
  logic        jumpLoad = 1'b0;
  logic [15:0] jumpTarget = '0;
  logic [4:0]  irqReq = '0;
  logic        retiPulse = 1'b0;
  logic [15:0] fetchAddr;
  logic        fetchExt;
  logic        irqAck;
  logic [2:0]  irqIdx;
  logic [15:0] retAddr;

  int checks = 0;
  int errors = 0;
  logic [15:0] expPc;
  bit done = 0;

  always #2.5 clk = ~clk;

  fetch_seq u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    fetchAdv = 0; jumpLoad = 0; irqReq = '0; retiPulse = 0;
  endtask

  task automatic doJump(logic [15:0] t);
    jumpLoad = 1; jumpTarget = t; step(); quiet(); expPc = t;
  endtask

  task automatic doReti();
    retiPulse = 1; step(); quiet();
  endtask

  function automatic int lowBit(logic [4:0] m);
    for (int i = 4; i >= 0; i--) if (m[i]) lowBit = i;
  endfunction

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    check("R1 reset addr", fetchAddr, 0);
    check("R1 reset ack", irqAck, 0);
    rstN = 1;
    step();
    check("R1 addr after release", fetchAddr, 0);
    check("R1 ack after release", irqAck, 0);
    expPc = 0;

    // advance sweep across the on-chip limit, strap high
    for (int n = 0; n < 4200; n++) begin
      check("R4 select", fetchExt, (expPc >= 16'h1000) ? 1 : 0);
      fetchAdv = 1; step(); expPc = expPc + 1;
      check("R2 advance", fetchAddr, expPc);
    end
    quiet();
    check("R4 select at 1068h", fetchExt, 1);

    // hold without strobe
    for (int n = 0; n < 4; n++) begin
      step();
      check("R2 hold", fetchAddr, expPc);
    end

    // strap low: always external
    extStrap = 0;
    doJump(16'h0000);
    check("R5 ext at 0000h", fetchExt, 1);
    doJump(16'h0FFF);
    check("R5 ext at 0FFFh", fetchExt, 1);
    doJump(16'h0800);
    check("R5 ext at 0800h", fetchExt, 1);
    extStrap = 1;
    #1;
    check("R4 int at 0800h", fetchExt, 0);
    doJump(16'h0FFF);
    check("R4 int at 0FFFh", fetchExt, 0);

    // jump with advance, wrap
    jumpLoad = 1; fetchAdv = 1; jumpTarget = 16'hFFFF; step(); quiet();
    check("R3 jump beats advance", fetchAddr, 16'hFFFF);
    fetchAdv = 1; step(); quiet();
    check("R2 wrap", fetchAddr, 16'h0000);

    // each source alone
    for (int k = 0; k < 5; k++) begin
      doJump(16'h0120 + 16'(k));
      irqReq = 5'(1 << k); fetchAdv = 1; step(); quiet();
      check("R6 vector", fetchAddr, 3 + 8 * k);
      check("R6 index", irqIdx, k);
      check("R10 ack high", irqAck, 1);
      check("R10 return addr", retAddr, 16'h0120 + 16'(k));
      step();
      check("R10 ack one cycle", irqAck, 0);
      doReti();
    end

    // all masks: lowest bit wins
    for (int m = 1; m < 32; m++) begin
      doJump(16'h2000 + 16'(m));
      irqReq = 5'(m); fetchAdv = 1; step(); quiet();
      check("R7 priority vector", fetchAddr, 3 + 8 * lowBit(5'(m)));
      check("R7 priority index", irqIdx, lowBit(5'(m)));
      doReti();
    end

    // request without strobe is ignored
    doJump(16'h0456);
    irqReq = 5'b00100; step(); step(); quiet();
    check("R8 no strobe addr", fetchAddr, 16'h0456);
    check("R8 no strobe ack", irqAck, 0);

    // in service: no nesting until return pulse
    irqReq = 5'b00010; fetchAdv = 1; step(); quiet();
    check("R9 first accept", fetchAddr, 16'h000B);
    step();
    irqReq = 5'b00001; fetchAdv = 1; step(); quiet();
    check("R9 blocked in service", fetchAddr, 16'h000C);
    check("R9 no ack in service", irqAck, 0);
    doReti();
    irqReq = 5'b00001; fetchAdv = 1; step(); quiet();
    check("R9 accept after return", fetchAddr, 16'h0003);
    check("R9 ack after return", irqAck, 1);
    doReti();

    // interrupt beats jump
    doJump(16'h3000);
    irqReq = 5'b10000; fetchAdv = 1; jumpLoad = 1; jumpTarget = 16'h5555; step(); quiet();
    check("R10 irq beats jump", fetchAddr, 16'h0023);
    check("R10 ret addr with jump", retAddr, 16'h3000);
    doReti();

    // reset again mid-run
    rstN = 0; #1;
    check("R1 async reset", fetchAddr, 0);
    step(); rstN = 1; step();
    check("R1 ack clear after reset", irqAck, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule